// File: doc/BRIEF.md
# Hamming Score-to-Time Neuron Bank

The block is a bank of classifier neurons. Each neuron keeps one stored binary pattern. All neurons see the same input vector and score it against their own pattern under one shared bitwise rule. The score is never presented as a number. A shared decision stage turns it into a single switching flag per neuron.

A run has three steps. A clear pulse starts a fresh run and zeroes every score and flag. During evaluation, any number of input vectors may be presented in turn, and the most recent one sets the scores. A fire pulse then starts the decision. In ramp mode, a shared counter climbs by one each cycle from zero. A neuron's flag rises on the first step where the counter plus a half-unit offset passes its score, so lower scores switch earlier. In pulse mode, a single step compares every score with a programmable amplitude plus the same half-unit offset. A done output marks the end of the decision.

Sorting the flags by their switching times gives k-loser selection, taking the first k to switch. The last k to switch give k-winner selection. Which of the two means "closest" depends on the rule chosen.

Top module: `hdn_array`

## Requirements
- R1: After reset, every flag and `done` are 0. The bank is idle, and `fire` and `eval_valid` have no effect until the first `clear`.
- R2: With `rule` = 0, a neuron's score is the number of bit positions where the input differs from its stored pattern.
- R3: With `rule` = 1, a neuron's score is the number of bit positions where the input equals its stored pattern.
- R4: With `rule` = 2, a neuron's score is the number of positions where both the input bit and the stored bit are 1. A `rule` value of 3 behaves as 0.
- R5: In ramp mode (`sweep_mode` = 0), count k clock edges after the edge that samples `fire`. After those k edges, a neuron's flag is 1 exactly when its score is at most k-1.
- R6: Once a flag is 1, it stays 1 until `clear` or reset.
- R7: In ramp mode, `done` is 1 from the (W+1)-th edge after the fire edge. In pulse mode, `done` is 1 from the fire edge itself. In both modes `done` holds until `clear`.
- R8: In pulse mode (`sweep_mode` = 1), the fire edge sets a neuron's flag exactly when its score is at most `amplitude`. The flags then no longer change until `clear`.
- R9: During evaluation, each edge with `eval_valid` high replaces the scores, so the last vector counts. After `fire`, `eval_valid` is ignored.
- R10: The edge that samples `clear` drops all flags and `done` to 0, zeroes all scores and reopens evaluation.
- R11: An edge with `wr_en` high stores `wr_pattern` into the neuron numbered `wr_idx` and leaves the other neurons unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Pattern write strobe |
| wr_idx | input | $clog2(N) | Neuron selected for the write |
| wr_pattern | input | W | Pattern to store |
| rule | input | 2 | 0 differ, 1 match, 2 both-one |
| sweep_mode | input | 1 | 0 ramp, 1 pulse |
| amplitude | input | $clog2(W+2) | Pulse threshold |
| clear | input | 1 | Start a new run |
| eval_valid | input | 1 | Input vector present |
| eval_vector | input | W | Shared input vector |
| fire | input | 1 | Start the decision |
| flags | output | N | One switching flag per neuron |
| done | output | 1 | Decision finished |

## Verification
The bench builds the bank with N=4 neurons of W=4 bits. With these values the bench can try every one of the 16 input vectors against several pattern sets, under all three rules. In ramp mode it checks the flags at every step of the sweep. In pulse mode it checks every amplitude from 0 to W+1, which includes both the all-switch case and the none-switch case. Each run also presents a decoy vector before the real one and another vector after fire, so the last-vector rule and the ignore-after-fire rule are exercised in every run.

// File: rtl/hdn_pkg.sv
package hdn_pkg;

    typedef enum logic [1:0] {
        CMP_DIFF = 2'd0,
        CMP_SAME = 2'd1,
        CMP_MASK = 2'd2
    } cmp_rule_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_EVAL  = 2'd1,
        PH_SWEEP = 2'd2
    } run_phase_e;

    typedef struct packed {
        logic load;
        logic step;
        logic shot;
    } cell_ctl_t;

    function automatic logic combine_bit(input logic [1:0] rule, input logic a, input logic b);
        case (rule)
            CMP_SAME: combine_bit = ~(a ^ b);
            CMP_MASK: combine_bit = a & b;
            default:  combine_bit = a ^ b;
        endcase
    endfunction

endpackage

// File: rtl/hdn_sweep.sv
module hdn_sweep
    import hdn_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          eval_valid,
    input  logic          fire,
    input  logic          sweep_mode,
    output logic [CW-1:0] ramp,
    output cell_ctl_t     ctl,
    output logic          done
);
    localparam logic [CW-1:0] RAMP_END = CW'(W + 1);

    run_phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            ramp  <= '0;
        end else if (clear) begin
            phase <= PH_EVAL;
            ramp  <= '0;
        end else begin
            case (phase)
                PH_EVAL: if (fire) begin
                    phase <= PH_SWEEP;
                    ramp  <= sweep_mode ? RAMP_END : '0;
                end
                PH_SWEEP: if (ramp != RAMP_END) ramp <= ramp + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        ctl.load = eval_valid && (phase == PH_EVAL);
        ctl.shot = fire && sweep_mode && (phase == PH_EVAL);
        ctl.step = (phase == PH_SWEEP) && (ramp != RAMP_END);
    end

    assign done = (phase == PH_SWEEP) && (ramp == RAMP_END);

    p_ramp_bound_r7: assert property (@(posedge clk) disable iff (rst)
        ramp <= RAMP_END);
    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !clear) |=> done);
    p_sweep_advance_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SWEEP && ramp != RAMP_END && !clear) |=> (ramp == CW'($past(ramp) + 1'b1)));
    p_idle_holds_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !clear) |=> !done);

endmodule

// File: rtl/hdn_cell.sv
module hdn_cell
    import hdn_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_pattern,
    input  logic [1:0]    rule,
    input  logic [W-1:0]  eval_vector,
    input  cell_ctl_t     ctl,
    input  logic [CW-1:0] ramp,
    input  logic [CW-1:0] amplitude,
    output logic          flag
);
    logic [W-1:0]  pattern;
    logic [CW-1:0] score;
    logic [CW-1:0] next_score;

    always_comb begin
        next_score = '0;
        for (int b = 0; b < W; b++)
            next_score = next_score + CW'(combine_bit(rule, eval_vector[b], pattern[b]));
    end

    always_ff @(posedge clk) begin
        if (rst) pattern <= '0;
        else if (wr_en) pattern <= wr_pattern;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) score <= '0;
        else if (ctl.load) score <= next_score;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) flag <= 1'b0;
        else if (ctl.shot) flag <= (score <= amplitude);
        else if (ctl.step && ramp >= score) flag <= 1'b1;
    end

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(clear));
    p_score_range_r2: assert property (@(posedge clk) disable iff (rst)
        score <= CW'(W));
    p_clear_drops_r10: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!flag && score == '0));

endmodule

// File: rtl/hdn_array.sv
module hdn_array
    import hdn_pkg::*;
#(
    parameter int N  = 4,
    parameter int W  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int CW = $clog2(W + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_pattern,
    input  logic [1:0]    rule,
    input  logic          sweep_mode,
    input  logic [CW-1:0] amplitude,
    input  logic          clear,
    input  logic          eval_valid,
    input  logic [W-1:0]  eval_vector,
    input  logic          fire,
    output logic [N-1:0]  flags,
    output logic          done
);
    cell_ctl_t     ctl;
    logic [CW-1:0] ramp;

    hdn_sweep #(.W(W), .CW(CW)) u_sweep (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .eval_valid (eval_valid),
        .fire       (fire),
        .sweep_mode (sweep_mode),
        .ramp       (ramp),
        .ctl        (ctl),
        .done       (done)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        hdn_cell #(.W(W), .CW(CW)) u_cell (
            .clk         (clk),
            .rst         (rst),
            .clear       (clear),
            .wr_en       (wr_en && (wr_idx == IW'(i))),
            .wr_pattern  (wr_pattern),
            .rule        (rule),
            .eval_vector (eval_vector),
            .ctl         (ctl),
            .ramp        (ramp),
            .amplitude   (amplitude),
            .flag        (flags[i])
        );
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (flags == '0 && !done));
    p_clear_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        clear |=> (flags == '0 && !done));

endmodule

// File: tb/hdn_array_test.sv
module hdn_array_test;
    localparam int N = 4;
    localparam int W = 4;
    localparam int IW = 2;
    localparam int CW = 3;
    localparam int CLK_PERIOD = 10;

    logic          clk = 0;
    logic          rst = 1;
    logic          wr_en = 0;
    logic [IW-1:0] wr_idx = '0;
    logic [W-1:0]  wr_pattern = '0;
    logic [1:0]    rule = 0;
    logic          sweep_mode = 0;
    logic [CW-1:0] amplitude = '0;
    logic          clear = 0;
    logic          eval_valid = 0;
    logic [W-1:0]  eval_vector = '0;
    logic          fire = 0;
    logic [N-1:0]  flags;
    logic          done;

    int checks = 0;
    int fails = 0;
    int pats [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    hdn_array #(.N(N), .W(W)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_pattern(wr_pattern),
        .rule(rule), .sweep_mode(sweep_mode), .amplitude(amplitude), .clear(clear),
        .eval_valid(eval_valid), .eval_vector(eval_vector), .fire(fire),
        .flags(flags), .done(done)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int score_of(input int r, input int v, input int p);
        int s = 0;
        for (int b = 0; b < W; b++) begin
            int vb = (v >> b) & 1;
            int pb = (p >> b) & 1;
            if (r == 1) s += (vb == pb) ? 1 : 0;
            else if (r == 2) s += vb * pb;
            else s += (vb != pb) ? 1 : 0;
        end
        return s;
    endfunction

    function automatic int expect_flags(input int r, input int v, input int lim);
        int f = 0;
        for (int i = 0; i < N; i++)
            if (score_of(r, v, pats[i]) <= lim) f |= (1 << i);
        return f;
    endfunction

    task automatic load_patterns(input int seed);
        for (int i = 0; i < N; i++) begin
            pats[i] = (seed * 7 + i * 5 + 3) & 15;
            wr_en = 1; wr_idx = IW'(i); wr_pattern = W'(pats[i]);
            tick();
        end
        wr_en = 0;
    endtask

    task automatic prime(input int v);
        clear = 1; tick(); clear = 0;
        check("R10 clear", {28'd0, flags} | (done << 4), 0);
        eval_valid = 1; eval_vector = W'(~v);
        tick();
        eval_vector = W'(v);
        tick();
        eval_valid = 0;
    endtask

    task automatic ramp_run(input int r, input int v);
        rule = 2'(r);
        prime(v);
        sweep_mode = 0; fire = 1;
        tick();
        fire = 0;
        eval_valid = 1; eval_vector = W'(v ^ 5);
        check("R5 start", int'(flags), 0);
        for (int k = 1; k <= W + 2; k++) begin
            tick();
            check(r == 0 ? "R2/R5 flags" : (r == 1 ? "R3/R5 flags" : "R4/R5 flags"),
                  int'(flags), expect_flags(r, v, k - 1));
            check("R7 ramp done", int'(done), (k >= W + 1) ? 1 : 0);
        end
        eval_valid = 0;
        check("R6 sticky", int'(flags), (1 << N) - 1);
    endtask

    task automatic pulse_run(input int r, input int v, input int a);
        rule = 2'(r);
        prime(v);
        sweep_mode = 1; amplitude = CW'(a); fire = 1;
        tick();
        fire = 0;
        check("R8 pulse flags", int'(flags), expect_flags(r, v, a));
        check("R7 pulse done", int'(done), 1);
        eval_valid = 1; eval_vector = W'(~v);
        tick(); tick();
        eval_valid = 0;
        check("R9 ignored after fire", int'(flags), expect_flags(r, v, a));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 0;
        check("R1 reset flags", int'(flags), 0);
        check("R1 reset done", int'(done), 0);
        fire = 1; sweep_mode = 1; eval_valid = 1;
        tick(); tick();
        fire = 0; eval_valid = 0;
        check("R1 idle fire ignored", int'(done), 0);

        for (int seed = 0; seed < 3; seed++) begin
            load_patterns(seed);
            for (int r = 0; r < 3; r++)
                for (int v = 0; v < 16; v++)
                    ramp_run(r, v);
        end

        load_patterns(1);
        for (int r = 0; r < 3; r++)
            for (int v = 0; v < 16; v += 3)
                for (int a = 0; a <= W + 1; a++)
                    pulse_run(r, v, a);

        // R4: rule value 3 behaves as the differ rule
        rule = 3; prime(6);
        sweep_mode = 1; amplitude = 3'd1; fire = 1; tick(); fire = 0;
        check("R4 rule3", int'(flags), expect_flags(0, 6, 1));

        // R11: overwrite one neuron only
        wr_en = 1; wr_idx = 2'd2; wr_pattern = 4'hF; tick(); wr_en = 0;
        pats[2] = 15;
        rule = 0; prime(15);
        sweep_mode = 1; amplitude = 3'd0; fire = 1; tick(); fire = 0;
        check("R11 single write", int'(flags), expect_flags(0, 15, 0));

        clear = 1; tick(); clear = 0;
        check("R10 clear after run", int'(flags) | (int'(done) << 4), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule